// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block holds the digital frequency dividers that sit around a frequency-multiplying phase-locked loop. It has two independent paths. The reference path takes a buffered copy of the crystal clock and divides it by a programmable factor R. The result is the final reference strobe. The feedback path takes the VCO clock through a power-of-two prescaler P and then a programmable modulo divider N. The result is the feedback strobe. Both strobes go to an external phase comparator.

When the loop is locked the two strobes run at the same rate. The VCO frequency is then the reference frequency times P·N/R, and with R = 1 it is an integer multiple of the reference. Software changes the divider fields while the loop runs. Each divider picks up a new field only when it wraps, so a period is never cut short.

Top module: `pll_div_chain`

## Requirements
- R1: The reference strobe repeats every Reff cycles of `ref_clk`. Reff is the 4-bit `ref_div_i` value (1..15).
- R2: A `ref_div_i` value of 0 divides by one, so the reference strobe is high on every `ref_clk` cycle.
- R3: The 2-bit `pre_sel_i` field selects the prescaler factor P: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R4: The feedback strobe repeats every P·Neff cycles of `vco_clk`. Neff is the 12-bit `fb_div_i` value (1..4095).
- R5: An `fb_div_i` value of 0 is treated as 1, so the feedback period is P cycles of `vco_clk`.
- R6: Each divider samples its field only at its own terminal count. A field change made mid-period lets the running period finish at the old length. The new length applies from the next strobe onward.
- R7: `rst` is synchronous and active high, and both clock domains sample it. While it is asserted both strobes are low. After release, the first reference strobe follows the Reff-th rising edge of `ref_clk`. The first feedback strobe follows the (P·Neff+1)-th rising edge of `vco_clk`; the extra edge comes from the registered prescaler stage.
- R8: When its divisor is above one, each strobe is high for exactly one cycle of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Buffered crystal clock that drives the reference path |
| vco_clk | input | 1 | VCO clock that drives the feedback path |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| ref_div_i | input | 4 | Reference divide factor R (0 means 1) |
| pre_sel_i | input | 2 | Prescaler select; the factor is 2 to the power of the field |
| fb_div_i | input | 12 | Feedback modulo factor N (0 means 1) |
| ref_strobe_o | output | 1 | Divided reference strobe, one `ref_clk` cycle wide |
| fb_strobe_o | output | 1 | Divided feedback strobe, one `vco_clk` cycle wide |

## Verification
Some properties are checked on every clock edge:
- each counter stays below its captured limit;
- a held divisor or prescaler select changes only at that stage's terminal count;
- strobes with a divisor above one never stay high for two consecutive cycles.

Other behaviour only the bench scenarios can show: the absolute period of each path, the P·N product on the feedback side, the zero-means-one decoding, the exact latency of the first strobe after reset, and the rule that a field written mid-period lets the current period finish at its old length.

// File: rtl/pll_div_pkg.sv
`timescale 1ns/1ps
package pll_div_pkg;
  // Prescaler select codes: factor is 2**code
  typedef enum logic [1:0] {
    PRE_BY1 = 2'd0,
    PRE_BY2 = 2'd1,
    PRE_BY4 = 2'd2,
    PRE_BY8 = 2'd3
  } pre_sel_e;

  localparam int REF_DIV_W_DEF = 4;
  localparam int PRE_SEL_W_DEF = 2;
  localparam int FB_DIV_W_DEF  = 12;
endpackage

// File: rtl/pdc_pow2_prescaler.sv
`timescale 1ns/1ps
module pdc_pow2_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W:0]   fac;
  logic             term;
  logic             tick_q;
  logic             rst_d;

  assign fac  = (CNT_W+1)'(1) << sel_q;
  assign term = ({1'b0, cnt_q} == (fac - (CNT_W+1)'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sel_q  <= sel_i;
      tick_q <= 1'b0;
      rst_d  <= 1'b1;
    end else begin
      rst_d  <= 1'b0;
      tick_q <= term;
      if (term) begin
        cnt_q <= '0;
        sel_q <= sel_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign tick_o = tick_q;

  // R3
  pre_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_q} < fac));

  // R3
  pre_tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_q && (sel_q != '0)) |=> !tick_q);

  // R6
  pre_sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_d && !$stable(sel_q)) |-> tick_q);
endmodule

// File: rtl/pdc_modulo_div.sv
`timescale 1ns/1ps
module pdc_modulo_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] div_i,
  output logic         strobe_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_q;
  logic [W-1:0] lim_nxt;
  logic         term;
  logic         strobe_q;
  logic         rst_d;

  // zero selects divide-by-one
  assign lim_nxt = (div_i == '0) ? W'(1) : div_i;
  assign term    = en && (cnt_q == (lim_q - W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      lim_q    <= lim_nxt;
      strobe_q <= 1'b0;
      rst_d    <= 1'b1;
    end else begin
      rst_d    <= 1'b0;
      strobe_q <= term;
      if (term) begin
        cnt_q <= '0;
        lim_q <= lim_nxt;
      end else if (en) begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  assign strobe_o = strobe_q;

  // R1
  mod_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < lim_q));

  // R8
  mod_strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_q && (lim_q > W'(1))) |=> !strobe_q);

  // R6
  mod_lim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_d && !$stable(lim_q)) |-> strobe_q);
endmodule

// File: rtl/pll_div_chain.sv
`timescale 1ns/1ps
module pll_div_chain
  import pll_div_pkg::*;
#(
  parameter int REF_DIV_W = REF_DIV_W_DEF,
  parameter int PRE_SEL_W = PRE_SEL_W_DEF,
  parameter int FB_DIV_W  = FB_DIV_W_DEF
) (
  input  logic                 ref_clk,
  input  logic                 vco_clk,
  input  logic                 rst,
  input  logic [REF_DIV_W-1:0] ref_div_i,
  input  logic [PRE_SEL_W-1:0] pre_sel_i,
  input  logic [FB_DIV_W-1:0]  fb_div_i,
  output logic                 ref_strobe_o,
  output logic                 fb_strobe_o
);
  logic pre_tick;

  // reference path: runs on every ref_clk cycle
  pdc_modulo_div #(.W(REF_DIV_W)) u_ref_div (
    .clk      (ref_clk),
    .rst      (rst),
    .en       (1'b1),
    .div_i    (ref_div_i),
    .strobe_o (ref_strobe_o)
  );

  // feedback path: prescaler first, then modulo counter
  pdc_pow2_prescaler #(.SEL_W(PRE_SEL_W)) u_fb_pre (
    .clk    (vco_clk),
    .rst    (rst),
    .sel_i  (pre_sel_i),
    .tick_o (pre_tick)
  );

  pdc_modulo_div #(.W(FB_DIV_W)) u_fb_div (
    .clk      (vco_clk),
    .rst      (rst),
    .en       (pre_tick),
    .div_i    (fb_div_i),
    .strobe_o (fb_strobe_o)
  );

  // R7
  fb_reset_low_chk: assert property (@(posedge vco_clk)
    $past(rst) |-> !fb_strobe_o);
endmodule

// File: tb/tb_pll_div_chain.sv
`timescale 1ns/1ps
module tb_pll_div_chain;
  logic        ref_clk = 1'b0;
  logic        vco_clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ref_div = 4'd1;
  logic [1:0]  pre_sel = 2'd0;
  logic [11:0] fb_div = 12'd1;
  logic        ref_strobe, fb_strobe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.0 ref_clk = ~ref_clk;   // 250 MHz
  always #1.5 vco_clk = ~vco_clk;

  pll_div_chain dut (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst(rst),
    .ref_div_i(ref_div), .pre_sel_i(pre_sel), .fb_div_i(fb_div),
    .ref_strobe_o(ref_strobe), .fb_strobe_o(fb_strobe)
  );

  // {R, prescaler select, N}
  localparam logic [17:0] VEC [6] = '{
    {4'd5,  2'd0, 12'd3},
    {4'd1,  2'd1, 12'd1},
    {4'd0,  2'd2, 12'd0},
    {4'd15, 2'd3, 12'd7},
    {4'd9,  2'd1, 12'd4095},
    {4'd2,  2'd3, 12'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge ref_clk); rst = 1'b1;
    repeat (3) @(posedge ref_clk);
    @(negedge ref_clk);
    chk("R7 ref low in reset", int'(ref_strobe), 0);
    chk("R7 fb low in reset", int'(fb_strobe), 0);
    rst = 1'b0;
  endtask

  task automatic meas_ref(output int t1, output int t2, output bit wbad);
    int k = 0;
    bit prev = 0;
    t1 = -1; t2 = -1; wbad = 0;
    while (t2 < 0 && k < 40000) begin
      @(posedge ref_clk); k++;
      @(negedge ref_clk);
      if (ref_strobe && prev) wbad = 1;
      prev = ref_strobe;
      if (ref_strobe) begin
        if (t1 < 0) t1 = k; else t2 = k;
      end
    end
  endtask

  task automatic meas_fb(output int t1, output int t2, output bit wbad);
    int k = 0;
    bit prev = 0;
    t1 = -1; t2 = -1; wbad = 0;
    while (t2 < 0 && k < 40000) begin
      @(posedge vco_clk); k++;
      @(negedge vco_clk);
      if (fb_strobe && prev) wbad = 1;
      prev = fb_strobe;
      if (fb_strobe) begin
        if (t1 < 0) t1 = k; else t2 = k;
      end
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int rt1, rt2, ft1, ft2;
    bit rwb, fwb;
    for (int i = 0; i < 6; i++) begin
      int r_eff, p_fac, n_eff;
      ref_div = VEC[i][17:14];
      pre_sel = VEC[i][13:12];
      fb_div  = VEC[i][11:0];
      r_eff = (ref_div == 0) ? 1 : int'(ref_div);
      p_fac = 1 << pre_sel;
      n_eff = (fb_div == 0) ? 1 : int'(fb_div);
      do_reset();
      fork
        meas_ref(rt1, rt2, rwb);
        meas_fb(ft1, ft2, fwb);
      join
      chk((ref_div == 0) ? "R2 ref first" : "R7 ref first", rt1, r_eff);
      chk((ref_div == 0) ? "R2 ref period" : "R1 ref period", rt2 - rt1, r_eff);
      chk("R7 fb first", ft1, p_fac * n_eff + 1);
      chk((fb_div == 0) ? "R5 fb period" : "R4 fb period", ft2 - ft1, p_fac * n_eff);
      if (r_eff > 1) chk("R8 ref width", int'(rwb), 0);
      if (p_fac * n_eff > 1) chk("R8 fb width", int'(fwb), 0);
    end

    // R3: prescaler alone, N = 1, every select value
    for (int s = 0; s < 4; s++) begin
      pre_sel = 2'(s); fb_div = 12'd1; ref_div = 4'd1;
      do_reset();
      meas_fb(ft1, ft2, fwb);
      chk("R3 prescale period", ft2 - ft1, 1 << s);
    end

    // R6: fields changed mid-period
    ref_div = 4'd6; pre_sel = 2'd0; fb_div = 12'd10;
    do_reset();
    fork
      meas_ref(rt1, rt2, rwb);
      meas_fb(ft1, ft2, fwb);
      begin
        repeat (2) @(posedge ref_clk);
        @(negedge ref_clk); ref_div = 4'd3;
      end
      begin
        repeat (3) @(posedge vco_clk);
        @(negedge vco_clk); fb_div = 12'd4;
      end
    join
    chk("R6 ref old period kept", rt1, 6);
    chk("R6 ref new period", rt2 - rt1, 3);
    chk("R6 fb old period kept", ft1, 11);
    chk("R6 fb new period", ft2 - ft1, 4);

    // R7: reset mid-run restarts both paths
    ref_div = 4'd4; pre_sel = 2'd1; fb_div = 12'd5;
    do_reset();
    repeat (7) @(posedge ref_clk);
    do_reset();
    fork
      meas_ref(rt1, rt2, rwb);
      meas_fb(ft1, ft2, fwb);
    join
    chk("R7 ref first after re-reset", rt1, 4);
    chk("R7 fb first after re-reset", ft1, 11);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule